// File: doc/BRIEF.md
# Relocatable Base-Page and Stack Address Generator

This block forms memory addresses for a small 8-bit processor core whose direct page and stack can both be moved. An 8-bit base-page register supplies the high byte of every direct-page address, and the 8-bit operand offset supplies the low byte. A stack pointer made of a high half and a low half gives the address of each push and each pull.

The stack pointer has two modes, chosen by an extend bit. With the bit clear, the high half only picks the stack page, and the low half wraps within that page. With the bit set, the two halves act as one 16-bit pointer. Building a 16-bit stack address costs one extra cycle, which the block signals with a stall.

The core's decoder drives the block one request per cycle:
- register loads from the accumulator;
- commands that set or clear the extend bit;
- push and pull requests;
- direct-page requests.

The block returns an address, a valid flag, a stall flag and an error flag. The registers are also visible as outputs so that the surrounding core can read them back.

Top module: `bpstk_addr_gen`

## Requirements
- R1: After reset the base-page output `base_page` is 0x00, so direct-page addresses fall in page 0.
- R2: A direct-page request with no stack request drives `mem_addr` = {base_page, zp_off} with `addr_valid` high in the same cycle.
- R3: After reset the stack pointer output `sp_out` is 0x0100, where the high byte is the stack page and the low byte is the in-page pointer.
- R4: With extend clear, a completed push or pull changes only `sp_out[7:0]`, wrapping 0x00↔0xFF within the page; `sp_out[15:8]` is unchanged.
- R5: With extend set, `sp_out` steps as one 16-bit value, so a borrow or carry out of the low byte changes the high byte (0x2000 push → 0x1FFF, then pull → 0x2000).
- R6: Reset clears the extend bit (`ext_mode` = 0). `ext_set` sets it and `ext_clr` clears it at the next clock edge. When both are asserted together, clear wins.
- R7: With extend set, the first cycle of a stack request raises `stall`, holds `addr_valid` low and leaves `sp_out` unchanged. The request, held for a second cycle, completes without a stall. With extend clear, `stall` stays low.
- R8: A push drives the current `sp_out` as the address and then decrements the pointer. A pull increments the pointer and drives the incremented value as the address, and that value becomes the new `sp_out`.
- R9: When push and pull are requested in the same cycle, `err` is high in that cycle and only the push is served.
- R10: `wr_en` with `wr_sel` loads `wr_data` at the next edge. The `wr_sel` codes are: 0 = base page, 1 = low stack half, 2 = high stack half, 3 = no effect. An address formed in the same cycle uses the old value. A written stack half overrides that half's push or pull update.
- R11: A stack request takes priority over a direct-page request in the same cycle. With no request, `addr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register load strobe |
| wr_sel | input | 2 | Load target: 0 base, 1 stack low, 2 stack high, 3 none |
| wr_data | input | 8 | Load value from the accumulator |
| ext_set | input | 1 | Set the 16-bit stack mode |
| ext_clr | input | 1 | Clear the 16-bit stack mode |
| push_req | input | 1 | Push request |
| pull_req | input | 1 | Pull request |
| zp_req | input | 1 | Direct-page access request |
| zp_off | input | 8 | Direct-page offset |
| mem_addr | output | 16 | Formed address |
| addr_valid | output | 1 | mem_addr is valid this cycle |
| stall | output | 1 | Extra address-formation cycle |
| err | output | 1 | Push and pull requested together |
| base_page | output | 8 | Current base page |
| sp_out | output | 16 | Current stack pointer {high, low} |
| ext_mode | output | 1 | Current extend bit |

## Verification
Two functions can fall in the same cycle:
- A register load can arrive together with an address request. The bench loads the base page while a direct-page request is active, and also loads a stack half while a push completes. It then checks that the address uses the old value and that the loaded byte wins over the pointer step.
- A push can collide with a pull. The bench judges the collision by the error flag, the address that is served and the resulting pointer.

// File: rtl/bpstk_pkg.sv
// Package: shared widths and the register-load target encoding.
// Assumes an 8-bit data path and a 16-bit address bus.
package bpstk_pkg;
    localparam int DW = 8;
    localparam int AW = 2 * DW;

    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_SPLO  = 2'd1,
        SEL_SPHI  = 2'd2,
        SEL_NONE  = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/bpstk_base_reg.sv
// Module: base-page register and direct-page address former.
// Assumes loads come from the accumulator and land on the next edge.
module bpstk_base_reg #(
    parameter int DW = 8,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld,
    input  logic [DW-1:0]   ld_data,
    input  logic [DW-1:0]   off,
    output logic [DW-1:0]   base,
    output logic [2*DW-1:0] addr
);
    // Purpose: hold the base page, loaded on request.
    always_ff @(posedge clk) begin
        if (!rst_n)  base <= RST_VAL;
        else if (ld) base <= ld_data;
    end

    // Purpose: join the base page and the offset into one address.
    always_comb addr = {base, off};
endmodule

// File: rtl/bpstk_sp_unit.sv
// Module: stack pointer with page-wrapped and full-width stepping.
// Assumes at most one completed step per cycle; loads override per half.
module bpstk_sp_unit #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] RST_VAL = 16'h0100
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext,
    input  logic            dec_go,
    input  logic            inc_go,
    input  logic            ld_lo,
    input  logic            ld_hi,
    input  logic [DW-1:0]   ld_data,
    output logic [2*DW-1:0] sp,
    output logic [2*DW-1:0] sp_inc
);
    localparam int AW = 2 * DW;

    logic [AW-1:0] sp_dec;
    logic [AW-1:0] sp_step;
    logic [AW-1:0] sp_nxt;

    // Purpose: compute the up and down steps for the active mode.
    always_comb begin
        if (ext) begin
            sp_inc = sp + AW'(1);
            sp_dec = sp - AW'(1);
        end else begin
            sp_inc = {sp[AW-1:DW], sp[DW-1:0] + DW'(1)};
            sp_dec = {sp[AW-1:DW], sp[DW-1:0] - DW'(1)};
        end
    end

    // Purpose: choose the step, then let a load override its own half.
    always_comb begin
        sp_step = dec_go ? sp_dec : (inc_go ? sp_inc : sp);
        sp_nxt  = sp_step;
        if (ld_lo) sp_nxt[DW-1:0]  = ld_data;
        if (ld_hi) sp_nxt[AW-1:DW] = ld_data;
    end

    // Purpose: hold the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) sp <= RST_VAL;
        else        sp <= sp_nxt;
    end
endmodule

// File: rtl/bpstk_stall_ctl.sv
// Module: extend bit and the one-cycle stall for full-width stack access.
// Assumes the requester holds a stalled stack request for one more cycle.
module bpstk_stall_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_cmd,
    input  logic clr_cmd,
    input  logic stk_req,
    output logic ext,
    output logic stall
);
    logic pend_q;

    // Purpose: hold the extend bit; clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       ext <= 1'b0;
        else if (clr_cmd) ext <= 1'b0;
        else if (set_cmd) ext <= 1'b1;
    end

    // Purpose: stall the first cycle of a full-width stack request.
    always_comb stall = stk_req & ext & ~pend_q;

    // Purpose: remember that the extra cycle has been spent.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= stall;
    end
endmodule

// File: rtl/bpstk_addr_gen.sv
// Module: top of the relocatable direct-page and stack address generator.
// Assumes one decoder request per cycle; a push beats a simultaneous pull
// and a stack request beats a direct-page request.
module bpstk_addr_gen
    import bpstk_pkg::*;
#(
    parameter logic [DW-1:0] BASE_RST = 8'h00,
    parameter logic [AW-1:0] SP_RST   = 16'h0100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          ext_set,
    input  logic          ext_clr,
    input  logic          push_req,
    input  logic          pull_req,
    input  logic          zp_req,
    input  logic [DW-1:0] zp_off,
    output logic [AW-1:0] mem_addr,
    output logic          addr_valid,
    output logic          stall,
    output logic          err,
    output logic [DW-1:0] base_page,
    output logic [AW-1:0] sp_out,
    output logic          ext_mode
);
    logic          stk_req;
    logic          push_go;
    logic          pull_go;
    logic          ld_base;
    logic          ld_lo;
    logic          ld_hi;
    logic [AW-1:0] zp_addr;
    logic [AW-1:0] sp_inc;

    // Purpose: decode the load target and the stack step enables.
    always_comb begin
        ld_base = wr_en && (wr_sel_e'(wr_sel) == SEL_BASE);
        ld_lo   = wr_en && (wr_sel_e'(wr_sel) == SEL_SPLO);
        ld_hi   = wr_en && (wr_sel_e'(wr_sel) == SEL_SPHI);
        stk_req = push_req | pull_req;
        push_go = push_req & ~stall;
        pull_go = pull_req & ~push_req & ~stall;
        err     = push_req & pull_req;
    end

    bpstk_base_reg #(.DW(DW), .RST_VAL(BASE_RST)) base_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ld_base),
        .ld_data (wr_data),
        .off     (zp_off),
        .base    (base_page),
        .addr    (zp_addr)
    );

    bpstk_sp_unit #(.DW(DW), .RST_VAL(SP_RST)) sp_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext     (ext_mode),
        .dec_go  (push_go),
        .inc_go  (pull_go),
        .ld_lo   (ld_lo),
        .ld_hi   (ld_hi),
        .ld_data (wr_data),
        .sp      (sp_out),
        .sp_inc  (sp_inc)
    );

    bpstk_stall_ctl stall_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_cmd (ext_set),
        .clr_cmd (ext_clr),
        .stk_req (stk_req),
        .ext     (ext_mode),
        .stall   (stall)
    );

    // Purpose: select the output address by priority and flag its validity.
    always_comb begin
        if (push_req)      mem_addr = sp_out;
        else if (pull_req) mem_addr = sp_inc;
        else               mem_addr = zp_addr;
        addr_valid = stk_req ? ~stall : zp_req;
    end
endmodule

// File: rtl/bpstk_addr_gen_chk.sv
// Module: assertion checker bound to the address generator top.
// Assumes it sees only the top's ports.
module bpstk_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [1:0]  wr_sel,
    input logic        ext_set,
    input logic        ext_clr,
    input logic        push_req,
    input logic        pull_req,
    input logic        zp_req,
    input logic [7:0]  zp_off,
    input logic [15:0] mem_addr,
    input logic        addr_valid,
    input logic        stall,
    input logic        err,
    input logic [7:0]  base_page,
    input logic [15:0] sp_out,
    input logic        ext_mode
);
    a_r2_zp_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (zp_req && !push_req && !pull_req) |-> (addr_valid && mem_addr == {base_page, zp_off}));

    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && (push_req || pull_req) && !wr_en) |=> $stable(sp_out[15:8]));

    a_r5_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && push_req && !stall && !wr_en) |=> (sp_out == $past(sp_out) - 16'd1));

    a_r7_one_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);

    a_r7_no_stall_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> !stall);

    a_r7_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !wr_en) |=> $stable(sp_out));

    a_r9_collision: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && pull_req) |-> (err && mem_addr == sp_out));

    a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clr |=> !ext_mode);

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_req && !pull_req && !zp_req) |-> !addr_valid);
endmodule

bind bpstk_addr_gen bpstk_addr_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .ext_set    (ext_set),
    .ext_clr    (ext_clr),
    .push_req   (push_req),
    .pull_req   (pull_req),
    .zp_req     (zp_req),
    .zp_off     (zp_off),
    .mem_addr   (mem_addr),
    .addr_valid (addr_valid),
    .stall      (stall),
    .err        (err),
    .base_page  (base_page),
    .sp_out     (sp_out),
    .ext_mode   (ext_mode)
);

// File: tb/bpstk_addr_gen_tb_top.sv
// Bench: vector table walk, then directed reset and corner-case tests.
module bpstk_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [7:0]  wr_data = 8'h00;
    logic        ext_set = 1'b0;
    logic        ext_clr = 1'b0;
    logic        push_req = 1'b0;
    logic        pull_req = 1'b0;
    logic        zp_req = 1'b0;
    logic [7:0]  zp_off = 8'h00;
    logic [15:0] mem_addr;
    logic        addr_valid;
    logic        stall;
    logic        err;
    logic [7:0]  base_page;
    logic [15:0] sp_out;
    logic        ext_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bpstk_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_set(ext_set), .ext_clr(ext_clr),
        .push_req(push_req), .pull_req(pull_req), .zp_req(zp_req),
        .zp_off(zp_off), .mem_addr(mem_addr), .addr_valid(addr_valid),
        .stall(stall), .err(err), .base_page(base_page), .sp_out(sp_out),
        .ext_mode(ext_mode)
    );

    // kind: 0 direct page, 1 push, 2 pull, 3 load base, 4 load low, 5 load high
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {3'd0, 8'h34, 16'h0034},
        {3'd3, 8'h12, 16'h0000},
        {3'd0, 8'h80, 16'h1280},
        {3'd1, 8'h00, 16'h0100},
        {3'd1, 8'h00, 16'h01FF},
        {3'd2, 8'h00, 16'h01FF},
        {3'd2, 8'h00, 16'h0100},
        {3'd5, 8'h20, 16'h0000},
        {3'd1, 8'h00, 16'h2000},
        {3'd0, 8'h01, 16'h1201},
        {3'd2, 8'h00, 16'h2000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; wr_sel = 2'd3; ext_set = 1'b0; ext_clr = 1'b0;
        push_req = 1'b0; pull_req = 1'b0; zp_req = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset base", 32'(base_page), 32'h00);
        chk("R3 reset sp", 32'(sp_out), 32'h0100);
        chk("R6 reset ext", 32'(ext_mode), 32'h0);
        chk("R11 idle valid", 32'(addr_valid), 32'h0);

        // Table walk: narrow stack mode, one operation per cycle.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            idle();
            wr_data = VEC[i][23:16];
            zp_off  = VEC[i][23:16];
            case (VEC[i][26:24])
                3'd0: zp_req = 1'b1;
                3'd1: push_req = 1'b1;
                3'd2: pull_req = 1'b1;
                3'd3: begin wr_en = 1'b1; wr_sel = 2'd0; end
                3'd4: begin wr_en = 1'b1; wr_sel = 2'd1; end
                default: begin wr_en = 1'b1; wr_sel = 2'd2; end
            endcase
            #2;
            if (VEC[i][26:24] <= 3'd2) begin
                chk("R2 R4 R8 table addr", 32'(mem_addr), 32'(VEC[i][15:0]));
                chk("R7 narrow no stall", 32'({stall, addr_valid}), 32'b01);
            end
        end
        @(negedge clk); idle(); #1;
        chk("R4 wrap kept page", 32'(sp_out), 32'h2000);
        chk("R10 base loaded", 32'(base_page), 32'h12);

        // R10: load in the same cycle as a direct-page access uses the old base.
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h55; zp_req = 1'b1; zp_off = 8'h10;
        #2; chk("R10 old base used", 32'(mem_addr), 32'h1210);
        @(negedge clk); idle(); #1;
        chk("R10 new base", 32'(base_page), 32'h55);

        // R10: wr_sel 3 changes nothing.
        @(negedge clk); wr_en = 1'b1; wr_sel = 2'd3; wr_data = 8'hEE;
        @(negedge clk); idle(); #1;
        chk("R10 sel3 base", 32'(base_page), 32'h55);
        chk("R10 sel3 sp", 32'(sp_out), 32'h2000);

        // R11: stack wins over direct page.
        @(negedge clk); push_req = 1'b1; zp_req = 1'b1; zp_off = 8'h77;
        #2; chk("R11 stack priority", 32'(mem_addr), 32'h2000);
        @(negedge clk); idle(); #1;
        chk("R4 narrow wrap low", 32'(sp_out), 32'h20FF);

        // R9: push and pull together.
        @(negedge clk); push_req = 1'b1; pull_req = 1'b1;
        #2; chk("R9 err flag", 32'(err), 32'h1);
        chk("R9 push address", 32'(mem_addr), 32'h20FF);
        @(negedge clk); idle(); #1;
        chk("R9 push served", 32'(sp_out), 32'h20FE);
        chk("R9 err clears", 32'(err), 32'h0);

        // R10: low-half load overrides a push in the same cycle.
        @(negedge clk); push_req = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = 8'h00;
        @(negedge clk); idle(); #1;
        chk("R10 load beats step", 32'(sp_out), 32'h2000);

        // R6: set extend; not visible until the edge.
        @(negedge clk); ext_set = 1'b1;
        #2; chk("R6 ext not yet", 32'(ext_mode), 32'h0);
        @(negedge clk); idle(); #1;
        chk("R6 ext set", 32'(ext_mode), 32'h1);

        // R7 + R5: stalled push with a borrow into the high half.
        @(negedge clk); push_req = 1'b1;
        #2; chk("R7 stall first", 32'({stall, addr_valid}), 32'b10);
        @(negedge clk); #1;
        chk("R7 pointer held", 32'(sp_out), 32'h2000);
        #1; chk("R7 second cycle", 32'({stall, addr_valid}), 32'b01);
        chk("R8 push address", 32'(mem_addr), 32'h2000);
        @(negedge clk); idle(); #1;
        chk("R5 borrow", 32'(sp_out), 32'h1FFF);

        // R5 + R8: stalled pull with a carry.
        @(negedge clk); pull_req = 1'b1;
        #2; chk("R7 pull stall", 32'(stall), 32'h1);
        @(negedge clk); #2;
        chk("R8 pull address", 32'(mem_addr), 32'h2000);
        @(negedge clk); idle(); #1;
        chk("R5 carry", 32'(sp_out), 32'h2000);

        // R6: clear beats set.
        @(negedge clk); ext_set = 1'b1; ext_clr = 1'b1;
        @(negedge clk); idle(); #1;
        chk("R6 clear wins", 32'(ext_mode), 32'h0);

        // R1 R3 R6: reset restores defaults.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk("R1 R3 reset again", 32'({base_page, sp_out}), 32'h000100);

        done = 1'b1;
        finish_run();
    end
endmodule